// File: doc/BRIEF.md
# Dual-Read Single-Write Register Bank

This block holds the architectural registers of a small processor datapath: a parameterised bank of words with two independent read ports and one write port. Each read port takes a register index and returns that register's contents through a purely combinational path, with no clock involved. The write port takes an index, a data word and an enable, and it commits on the falling edge of the clock. The datapath can therefore launch a write in the first half of a cycle and read the result back in the second half.

An active-high clear input zeroes the whole bank as soon as it rises. It does not wait for a clock edge, and it overrides any write that is pending at the same time. Index 0 is an ordinary storage location and can be written like any other.

Top module: `regbank2r1w`

## Requirements
- R1: While `clr` is 1, every register reads as zero. This takes effect as soon as `clr` rises, with no clock edge needed, including after reset and in the middle of operation.
- R2: At a falling edge of `clk` with `wr_en` = 1 and `clr` = 0, `wr_data` is stored into the register selected by `wr_idx`. Port A (`rd_idx_a` → `rd_data_a`) returns the new value afterwards.
- R3: Port B (`rd_idx_b` → `rd_data_b`) returns the value stored by any write to the index it selects.
- R4: A falling edge with `wr_en` = 0 changes no register.
- R5: A rising edge of `clk` never writes. Between a rising edge and the following falling edge, a read of the target index still returns the old value, even while `wr_en` = 1.
- R6: The read outputs follow a change of read index combinationally, without any clock edge.
- R7: When both ports select the same index, they return identical data.
- R8: Index 0 is writable and holds the value written to it. It is not tied to zero.
- R9: `clr` = 1 takes priority over a write that arrives at the same falling edge. The target register stays zero.
- R10: A write changes only the register it selects. All other registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its falling edge |
| clr | input | 1 | Asynchronous active-high clear of the whole bank |
| wr_en | input | 1 | Write enable, sampled at the falling edge |
| wr_idx | input | IDX_W (5) | Index of the register to write |
| wr_data | input | WIDTH (32) | Data to write |
| rd_idx_a | input | IDX_W (5) | Read index, port A |
| rd_data_a | output | WIDTH (32) | Contents of register `rd_idx_a` |
| rd_idx_b | input | IDX_W (5) | Read index, port B |
| rd_data_b | output | WIDTH (32) | Contents of register `rd_idx_b` |

## Verification
The bench builds the bank with its default parameters: 32 registers, 32 bits wide, 5-bit indices. With these values every index can be visited, including index 0 and index 31 at the extremes of the index range, and every register is filled with a distinct pattern, so a wrong decode or a leaked write shows up as a mismatch. The full-width data words set each bit position to both levels somewhere in the bank. The small depth also lets the bench walk the entire bank after each clear and after a disabled write.

// File: rtl/regbank2r1w.sv
module regbank2r1w #(
  parameter int NREGS = 32,
  parameter int WIDTH = 32,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx_a,
  output logic [WIDTH-1:0] rd_data_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [WIDTH-1:0] rd_data_b
);

  logic [WIDTH-1:0] bank [NREGS];

  always_ff @(negedge clk or posedge clr) begin
    if (clr) begin
      for (int i = 0; i < NREGS; i++) bank[i] <= '0;
    end else if (wr_en) begin
      bank[wr_idx] <= wr_data;
    end
  end

  assign rd_data_a = bank[rd_idx_a];
  assign rd_data_b = bank[rd_idx_b];

  // Record of the last falling-edge write, held for the checks below.
  logic             seen_wr;
  logic [IDX_W-1:0] seen_idx;
  logic [WIDTH-1:0] seen_data;

  always_ff @(negedge clk or posedge clr) begin
    if (clr) begin
      seen_wr   <= 1'b0;
      seen_idx  <= '0;
      seen_data <= '0;
    end else begin
      seen_wr   <= wr_en;
      seen_idx  <= wr_idx;
      seen_data <= wr_data;
    end
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk)
    clr |-> (rd_data_a == '0 && rd_data_b == '0));

  // R2
  write_vis_a_chk: assert property (@(posedge clk) disable iff (clr)
    (seen_wr && rd_idx_a == seen_idx) |-> rd_data_a == seen_data);

  // R3
  write_vis_b_chk: assert property (@(posedge clk) disable iff (clr)
    (seen_wr && rd_idx_b == seen_idx) |-> rd_data_b == seen_data);

  // R7
  same_idx_chk: assert property (@(posedge clk) disable iff (clr)
    (rd_idx_a == rd_idx_b) |-> rd_data_a == rd_data_b);

endmodule

// File: tb/test_regbank2r1w.sv
module test_regbank2r1w;
  localparam int NREGS = 32;
  localparam int WIDTH = 32;
  localparam int IDX_W = 5;

  logic             clk = 1'b0;
  logic             clr = 1'b1;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [IDX_W-1:0] rd_idx_a = '0;
  logic [IDX_W-1:0] rd_idx_b = '0;
  logic [WIDTH-1:0] rd_data_a;
  logic [WIDTH-1:0] rd_data_b;

  always #10 clk = ~clk;

  regbank2r1w #(.NREGS(NREGS), .WIDTH(WIDTH)) i_regbank2r1w (
    .clk(clk), .clr(clr), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
    .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b)
  );

  typedef struct {
    int               req;
    logic [IDX_W-1:0] ia;
    logic [IDX_W-1:0] ib;
    logic [WIDTH-1:0] ea;
    logic [WIDTH-1:0] eb;
  } item_t;

  item_t            sb[$];
  event             chk_ev;
  logic [WIDTH-1:0] model [NREGS];
  int unsigned      n_cmp = 0;
  int unsigned      n_bad = 0;
  bit               done = 0;

  function automatic logic [WIDTH-1:0] pat(input int i);
    return 32'h9E37_79B9 * (i + 1);
  endfunction

  // Monitor: pops expected items and compares them with the outputs.
  initial forever begin
    @(chk_ev);
    #1;
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_cmp++;
      if (rd_data_a !== it.ea) begin
        n_bad++;
        $display("FAIL R%0d port A idx %0d: actual %h expected %h", it.req, it.ia, rd_data_a, it.ea);
      end
      n_cmp++;
      if (rd_data_b !== it.eb) begin
        n_bad++;
        $display("FAIL R%0d port B idx %0d: actual %h expected %h", it.req, it.ib, rd_data_b, it.eb);
      end
    end
  end

  // Driver: sets the read indices and pushes the model's expectation.
  task automatic sample(input int ia, input int ib, input int req);
    item_t it;
    rd_idx_a = IDX_W'(ia);
    rd_idx_b = IDX_W'(ib);
    it.req = req; it.ia = IDX_W'(ia); it.ib = IDX_W'(ib);
    it.ea = model[ia]; it.eb = model[ib];
    sb.push_back(it);
    ->chk_ev;
    #3;
  endtask

  task automatic do_write(input int idx, input logic [WIDTH-1:0] d, input logic en);
    @(posedge clk); #2;
    wr_idx = IDX_W'(idx); wr_data = d; wr_en = en;
    @(negedge clk); #2;
    wr_en = 1'b0;
    if (en && !clr) model[idx] = d;
  endtask

  task automatic zero_model();
    for (int i = 0; i < NREGS; i++) model[i] = '0;
  endtask

  initial begin
    zero_model();
    #25;
    // R1: state while the clear is held from time zero
    for (int i = 0; i < NREGS; i++) sample(i, NREGS - 1 - i, 1);
    @(posedge clk); #3; clr = 1'b0;

    // R2 and R8: fill every register, index 0 included
    for (int i = 0; i < NREGS; i++) do_write(i, pat(i), 1'b1);
    // R2, R3 and R10: every index on both ports, with distinct data
    for (int i = 0; i < NREGS; i++) sample(i, (i + 7) % NREGS, 10);
    // R7: both ports on the same index
    for (int i = 0; i < NREGS; i += 5) sample(i, i, 7);
    // R6: index changes between clock edges
    @(posedge clk); #4;
    sample(3, 30, 6); sample(30, 3, 6); sample(31, 0, 6);

    // R4: a disabled write leaves the whole bank untouched
    do_write(5, 32'hDEAD_BEEF, 1'b0);
    for (int i = 0; i < NREGS; i++) sample(i, (i + 1) % NREGS, 4);

    // R5: the rising edge does not write; the falling edge does
    @(negedge clk); #2;
    wr_idx = 5'd9; wr_data = 32'h1234_5678; wr_en = 1'b1;
    @(posedge clk); #2;
    sample(9, 9, 5);
    @(negedge clk); #2;
    wr_en = 1'b0; model[9] = 32'h1234_5678;
    sample(9, 8, 5);
    sample(10, 9, 3);

    // R8: index 0 takes a new value
    do_write(0, 32'hFFFF_0001, 1'b1);
    sample(0, 0, 8);
    sample(1, 0, 8);

    // R1: clear raised between edges takes effect without a clock edge
    @(negedge clk); #5;
    clr = 1'b1; zero_model();
    sample(9, 0, 1);
    for (int i = 0; i < NREGS; i++) sample(i, NREGS - 1 - i, 1);
    @(posedge clk); #3; clr = 1'b0;

    // R9: clear overrides a write at the same falling edge
    do_write(12, 32'hCAFE_F00D, 1'b1);
    @(posedge clk); #2;
    wr_idx = 5'd12; wr_data = 32'h5555_AAAA; wr_en = 1'b1; clr = 1'b1;
    zero_model();
    @(negedge clk); #2;
    wr_en = 1'b0;
    sample(12, 12, 9);
    @(posedge clk); #3; clr = 1'b0;
    sample(12, 13, 9);

    // R3: port B sees a fresh write after the clear
    do_write(31, 32'h0BAD_F00D, 1'b1);
    sample(0, 31, 3);
    sample(31, 30, 2);

    #10;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule